// File: doc/BRIEF.md
# Stack-Machine Datapath Register Bank

This block is the register store of a microcoded stack machine. It holds the working registers of the datapath: a memory word-address register, a memory data register, a program counter, an 8-bit instruction byte register, stack pointer, local-frame base, constant-pool base, top-of-stack copy, a scratch register and the holding register that feeds the ALU's left operand. Each cycle the microinstruction picks one register to place on the B bus and names any set of registers that capture the C bus at the next rising edge.

The bank also fronts memory. The word-address register is turned into a byte address, the program counter serves as the byte address for instruction fetches, and the read, write and fetch requests of the microinstruction become registered strobes. A read returns a word into the memory data register. A fetch returns one byte into the instruction byte register. The ALU, the sequencer and the memories lie outside this block.

Top module: `dp_regfile`

## Requirements
- R1: After reset every register, including the byte register, holds zero and all three memory strobes are low.
- R2: `b_sel` places a register on `b_bus` as follows: 0 data register, 1 program counter, 4 stack pointer, 5 frame base, 6 pool base, 7 top-of-stack, 8 scratch.
- R3: `b_sel` 2 places the byte register on `b_bus` with bit 7 copied into all upper bits; `b_sel` 3 places it with zero upper bits.
- R4: `b_sel` 9 to 15 drive `b_bus` to zero.
- R5: Bit k of `c_mask` loads `c_bus` into one register at the rising edge. The bit order is 8 holding, 7 scratch, 6 top-of-stack, 5 pool base, 4 frame base, 3 stack pointer, 2 program counter, 1 data register, 0 word-address register. Any number of bits may be set. A register whose bit is clear keeps its value.
- R6: `a_bus` always carries the holding register, and no other register reaches it.
- R7: `mem_addr` is the word-address register shifted left by two. The two low bits are zero and the top two register bits are dropped.
- R8: A request on `rd_req`, `wr_req` or `fetch_req` appears on `mem_rd`, `mem_wr` or `mem_fetch` during the following cycle. In that cycle the address outputs carry the register values written at the same edge, and `mem_wdata` carries the data register.
- R9: While `mem_rd` is high, the next rising edge loads `mem_rdata` into the data register.
- R10: While `mem_fetch` is high, the next rising edge loads `mem_fbyte` into the byte register. The byte is addressed by `fetch_addr`, which equals the program counter.
- R11: If a returning read and a C-bus write target the data register at the same edge, the read data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| b_sel | input | 4 | B-bus source code |
| c_mask | input | 9 | C-bus destination mask |
| c_bus | input | 32 | Result to be written |
| rd_req | input | 1 | Read request of the current microinstruction |
| wr_req | input | 1 | Write request of the current microinstruction |
| fetch_req | input | 1 | Byte fetch request of the current microinstruction |
| mem_rdata | input | 32 | Word returned by memory |
| mem_fbyte | input | 8 | Byte returned by the instruction memory |
| b_bus | output | 32 | Selected B-bus operand |
| a_bus | output | 32 | Holding register for the ALU left input |
| mem_addr | output | 32 | Byte address of the data access |
| mem_wdata | output | 32 | Write data (data register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| fetch_addr | output | 32 | Byte address of the fetch |
| mem_fetch | output | 1 | Fetch strobe |

## Verification
The bench builds the bank with its default 32-bit word and 8-bit byte, so sign extension on code 2 spreads bit 7 over 24 upper bits. Program counter values of 0x80 and 0x11 return bytes on either side of that sign boundary. The same width lets a word address with its top two bits set reach `mem_addr` and lose those bits. The cycle model in the bench runs directed sequences for the read-versus-write collision and then a long random stream of masks, codes and strobes, and compares its results against the outputs on every cycle.

// File: rtl/dpath_pkg.sv
package dpath_pkg;

    localparam int NDEST = 9;
    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_MDR  = 4'd0,
        SRC_PC   = 4'd1,
        SRC_MBRS = 4'd2,
        SRC_MBRZ = 4'd3,
        SRC_SP   = 4'd4,
        SRC_LV   = 4'd5,
        SRC_CPP  = 4'd6,
        SRC_TOS  = 4'd7,
        SRC_OPC  = 4'd8
    } bsrc_e;

    // destination indices, equal to the c_mask bit positions
    localparam int D_MAR = 0;
    localparam int D_MDR = 1;
    localparam int D_PC  = 2;
    localparam int D_SP  = 3;
    localparam int D_LV  = 4;
    localparam int D_CPP = 5;
    localparam int D_TOS = 6;
    localparam int D_OPC = 7;
    localparam int D_H   = 8;

    typedef struct packed {
        logic rd;
        logic wr;
        logic fetch;
    } strobe_t;

endpackage

// File: rtl/dp_bsel.sv
module dp_bsel
    import dpath_pkg::*;
#(
    parameter int DW     = 32,
    parameter int BYTE_W = 8
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DW-1:0]     mdr,
    input  logic [DW-1:0]     pc,
    input  logic [BYTE_W-1:0] mbr,
    input  logic [DW-1:0]     sp,
    input  logic [DW-1:0]     lv,
    input  logic [DW-1:0]     cpp,
    input  logic [DW-1:0]     tos,
    input  logic [DW-1:0]     opc,
    output logic [DW-1:0]     bus
);
    localparam int EXT_W = DW - BYTE_W;

    logic [DW-1:0] mbr_sx;
    logic [DW-1:0] mbr_zx;

    generate
        if (EXT_W > 0) begin : g_ext
            assign mbr_sx = {{EXT_W{mbr[BYTE_W-1]}}, mbr};
            assign mbr_zx = {{EXT_W{1'b0}}, mbr};
        end else begin : g_noext
            assign mbr_sx = mbr[DW-1:0];
            assign mbr_zx = mbr[DW-1:0];
        end
    endgenerate

    always_comb begin
        case (sel)
            SRC_MDR:  bus = mdr;
            SRC_PC:   bus = pc;
            SRC_MBRS: bus = mbr_sx;
            SRC_MBRZ: bus = mbr_zx;
            SRC_SP:   bus = sp;
            SRC_LV:   bus = lv;
            SRC_CPP:  bus = cpp;
            SRC_TOS:  bus = tos;
            SRC_OPC:  bus = opc;
            default:  bus = '0;
        endcase
    end

endmodule

// File: rtl/dp_regs.sv
module dp_regs
    import dpath_pkg::*;
#(
    parameter int DW     = 32,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NDEST-1:0]         c_mask,
    input  logic [DW-1:0]            c_bus,
    input  logic                     rd_fill,
    input  logic [DW-1:0]            rd_data,
    input  logic                     fetch_fill,
    input  logic [BYTE_W-1:0]        fetch_byte,
    output logic [NDEST-1:0][DW-1:0] regs_o,
    output logic [BYTE_W-1:0]        mbr_o
);
    typedef struct packed {
        logic [NDEST-1:0][DW-1:0] r;
        logic [BYTE_W-1:0]        mbr;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NDEST; i++) begin
            if (c_mask[i]) st_d.r[i] = c_bus;
        end
        // memory return overrides a C-bus write to the data register
        if (rd_fill)    st_d.r[D_MDR] = rd_data;
        if (fetch_fill) st_d.mbr      = fetch_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs_o = st_q.r;
    assign mbr_o  = st_q.mbr;

    p_mem_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fill |=> regs_o[D_MDR] == $past(rd_data));

    p_fetch_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_fill |=> mbr_o == $past(fetch_byte));

    p_hold_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !c_mask[D_H] |=> regs_o[D_H] == $past(regs_o[D_H]));

    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_mask[D_TOS] |=> regs_o[D_TOS] == $past(c_bus));

endmodule

// File: rtl/dp_memif.sv
module dp_memif
    import dpath_pkg::*;
#(
    parameter int DW     = 32,
    parameter int BYTE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          wr_req,
    input  logic          fetch_req,
    input  logic [DW-1:0] mar,
    input  logic [DW-1:0] pc,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] fetch_addr,
    output logic          rd_o,
    output logic          wr_o,
    output logic          fetch_o
);
    localparam int BYTES_PER_WORD = DW / BYTE_W;
    localparam int ADDR_SH        = $clog2(BYTES_PER_WORD);

    strobe_t stb_d, stb_q;

    always_comb begin
        stb_d.rd    = rd_req;
        stb_d.wr    = wr_req;
        stb_d.fetch = fetch_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= '0;
        else        stb_q <= stb_d;
    end

    assign mem_addr   = mar << ADDR_SH;
    assign fetch_addr = pc;
    assign rd_o       = stb_q.rd;
    assign wr_o       = stb_q.wr;
    assign fetch_o    = stb_q.fetch;

    p_rd_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_o);

    p_wr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> !wr_o);

    p_fetch_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> fetch_o);

endmodule

// File: rtl/dp_regfile.sv
module dp_regfile
    import dpath_pkg::*;
#(
    parameter int DW     = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        b_sel,
    input  logic [8:0]        c_mask,
    input  logic [DW-1:0]     c_bus,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              fetch_req,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [BYTE_W-1:0] mem_fbyte,
    output logic [DW-1:0]     b_bus,
    output logic [DW-1:0]     a_bus,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DW-1:0]     fetch_addr,
    output logic              mem_fetch
);
    logic [NDEST-1:0][DW-1:0] bank;
    logic [BYTE_W-1:0]        mbr;

    dp_regs #(.DW(DW), .BYTE_W(BYTE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .c_mask     (c_mask),
        .c_bus      (c_bus),
        .rd_fill    (mem_rd),
        .rd_data    (mem_rdata),
        .fetch_fill (mem_fetch),
        .fetch_byte (mem_fbyte),
        .regs_o     (bank),
        .mbr_o      (mbr)
    );

    dp_bsel #(.DW(DW), .BYTE_W(BYTE_W)) u_bsel (
        .sel (b_sel),
        .mdr (bank[D_MDR]),
        .pc  (bank[D_PC]),
        .mbr (mbr),
        .sp  (bank[D_SP]),
        .lv  (bank[D_LV]),
        .cpp (bank[D_CPP]),
        .tos (bank[D_TOS]),
        .opc (bank[D_OPC]),
        .bus (b_bus)
    );

    dp_memif #(.DW(DW), .BYTE_W(BYTE_W)) u_memif (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .fetch_req  (fetch_req),
        .mar        (bank[D_MAR]),
        .pc         (bank[D_PC]),
        .mem_addr   (mem_addr),
        .fetch_addr (fetch_addr),
        .rd_o       (mem_rd),
        .wr_o       (mem_wr),
        .fetch_o    (mem_fetch)
    );

    assign a_bus     = bank[D_H];
    assign mem_wdata = bank[D_MDR];

    p_idle_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_sel > 4'd8) |-> b_bus == '0);

    p_a_follows_h_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_mask[D_H] |=> a_bus == $past(c_bus));

endmodule

// File: tb/dp_regfile_test.sv
`timescale 1ns/1ps
module dp_regfile_test;

    localparam logic [31:0] RD_KEY = 32'h5A5A_0F0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  b_sel = '0;
    logic [8:0]  c_mask = '0;
    logic [31:0] c_bus = '0;
    logic        rd_req = 1'b0, wr_req = 1'b0, fetch_req = 1'b0;
    logic [31:0] mem_rdata;
    logic [7:0]  mem_fbyte;
    logic [31:0] b_bus, a_bus, mem_addr, mem_wdata, fetch_addr;
    logic        mem_rd, mem_wr, mem_fetch;

    always #10 clk = ~clk;

    // simple memory: data depends on the address
    assign mem_rdata = mem_addr ^ RD_KEY;
    assign mem_fbyte = fetch_addr[7:0] ^ 8'h03;

    dp_regfile uut (
        .clk(clk), .rst_n(rst_n), .b_sel(b_sel), .c_mask(c_mask), .c_bus(c_bus),
        .rd_req(rd_req), .wr_req(wr_req), .fetch_req(fetch_req),
        .mem_rdata(mem_rdata), .mem_fbyte(mem_fbyte),
        .b_bus(b_bus), .a_bus(a_bus), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .fetch_addr(fetch_addr), .mem_fetch(mem_fetch)
    );

    // reference model state; index = mask bit (0 word addr ... 8 holding)
    logic [31:0] m_r [9];
    logic [7:0]  m_mbr;
    logic        m_rd, m_wr, m_f;
    int checks = 0;
    int fails  = 0;

    function automatic logic [31:0] exp_b(input logic [3:0] s);
        case (s)
            4'd0: return m_r[1];
            4'd1: return m_r[2];
            4'd2: return {{24{m_mbr[7]}}, m_mbr};
            4'd3: return {24'h0, m_mbr};
            4'd4: return m_r[3];
            4'd5: return m_r[4];
            4'd6: return m_r[5];
            4'd7: return m_r[6];
            4'd8: return m_r[7];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [3:0] s);
        if (s == 4'd2 || s == 4'd3) return "R3";
        if (s > 4'd8) return "R4";
        return "R2";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input logic [3:0] sel, input logic [8:0] mask,
                        input logic [31:0] cv, input logic r, input logic w, input logic f);
        logic [31:0] n_r [9];
        logic [7:0]  n_mbr;
        @(negedge clk);
        b_sel = sel; c_mask = mask; c_bus = cv;
        rd_req = r; wr_req = w; fetch_req = f;
        #2;
        chk(tag,  b_bus, exp_b(sel));
        chk("R6", a_bus, m_r[8]);
        chk("R7", mem_addr, {m_r[0][29:0], 2'b00});
        chk("R8", {29'h0, mem_rd, mem_wr, mem_fetch}, {29'h0, m_rd, m_wr, m_f});
        chk("R8", mem_wdata, m_r[1]);
        chk("R10", fetch_addr, m_r[2]);
        for (int i = 0; i < 9; i++) n_r[i] = mask[i] ? cv : m_r[i];
        if (m_rd) n_r[1] = {m_r[0][29:0], 2'b00} ^ RD_KEY;
        n_mbr = m_f ? (m_r[2][7:0] ^ 8'h03) : m_mbr;
        @(posedge clk);
        for (int i = 0; i < 9; i++) m_r[i] = n_r[i];
        m_mbr = n_mbr;
        m_rd = r; m_wr = w; m_f = f;
    endtask

    initial begin
        #(20 * 100000);
        checks++; fails++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 9; i++) m_r[i] = '0;
        m_mbr = '0; m_rd = 0; m_wr = 0; m_f = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen through every code
        for (int s = 0; s < 9; s++) step("R1", 4'(s), 9'h0, 32'h0, 0, 0, 0);
        // R5: one write to all destinations, then distinct values each
        step("R5", 4'd15, 9'h1FF, 32'h1111_1111, 0, 0, 0);
        for (int s = 0; s < 9; s++) step("R5", 4'(s), 9'h0, 32'h0, 0, 0, 0);
        for (int i = 0; i < 9; i++)
            step("R5", 4'd15, 9'(1 << i), 32'hA000_0000 + 32'(i * 32'h0101_0101), 0, 0, 0);
        // R2: read back each register
        for (int s = 0; s < 9; s++) step(tag_for(4'(s)), 4'(s), 9'h0, 32'h0, 0, 0, 0);
        // R4: unused codes
        for (int s = 9; s < 16; s++) step("R4", 4'(s), 9'h0, 32'h0, 0, 0, 0);
        // R10 / R3: fetch a byte with bit 7 set, then one with bit 7 clear
        step("R10", 4'd15, 9'h004, 32'h0000_0080, 0, 0, 1);
        step("R10", 4'd15, 9'h0, 32'h0, 0, 0, 0);
        step("R3", 4'd2, 9'h0, 32'h0, 0, 0, 0);
        step("R3", 4'd3, 9'h0, 32'h0, 0, 0, 0);
        step("R10", 4'd15, 9'h004, 32'h0000_0011, 0, 0, 1);
        step("R10", 4'd15, 9'h0, 32'h0, 0, 0, 0);
        step("R3", 4'd2, 9'h0, 32'h0, 0, 0, 0);
        step("R3", 4'd3, 9'h0, 32'h0, 0, 0, 0);
        // R9: read into the data register
        step("R9", 4'd15, 9'h001, 32'h0000_0005, 1, 0, 0);
        step("R9", 4'd15, 9'h0, 32'h0, 0, 0, 0);
        step("R9", 4'd0, 9'h0, 32'h0, 0, 0, 0);
        // R11: read return and C-bus write to the data register collide
        step("R11", 4'd15, 9'h001, 32'h0000_0009, 1, 0, 0);
        step("R11", 4'd15, 9'h002, 32'hDEAD_BEEF, 0, 0, 0);
        step("R11", 4'd0, 9'h0, 32'h0, 0, 0, 0);
        // R7: top word-address bits fall off
        step("R7", 4'd15, 9'h001, 32'hC000_0001, 0, 0, 0);
        step("R7", 4'd15, 9'h0, 32'h0, 0, 0, 0);
        // R8: write strobe with data register contents
        step("R8", 4'd15, 9'h003, 32'h0000_0123, 0, 1, 0);
        step("R8", 4'd15, 9'h0, 32'h0, 0, 0, 0);
        // random stream
        for (int n = 0; n < 400; n++) begin
            logic [3:0] s;
            s = 4'($urandom);
            step(tag_for(s), s, 9'($urandom), $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule